// File: doc/BRIEF.md
# Four-Way Instruction Translation Buffer Replacement Tracker

This block keeps a six-bit recency code for a four-way, fully associative instruction translation buffer and names the way to overwrite when a miss brings in a new mapping. Each pair of ways has one bit in the code that records which of the two was used more recently. A use of a way drives the three bits that involve that way to the values meaning "this way is newer". All other bits are left as they were.

The victim is decoded directly from the code. Each way is matched against a fixed three-bit pattern, and no counters are involved. Lookup hardware reports hits with a way index. The refill sequencer raises a refill request, reads the victim index in the same cycle, and the tracker then marks that way as newest on the clock edge. Software can load the whole code at once. A code that matches no way's pattern raises an error flag.

Top module: `itlb_lru_track`

## Requirements
- R1: After reset the code is 6'b000000, the victim index is 3 and the error flag is 0.
- R2: With only a hit on way 0 pending, the next code has bits 5, 4 and 3 cleared and bits 2..0 unchanged.
- R3: With only a hit on way 1 pending, the next code has bit 5 set, bits 2 and 1 cleared, and bits 4, 3 and 0 unchanged.
- R4: With only a hit on way 2 pending, the next code has bits 4 and 2 set, bit 0 cleared, and bits 5, 3 and 1 unchanged.
- R5: With only a hit on way 3 pending, the next code has bits 3, 1 and 0 set and bits 5, 4 and 2 unchanged.
- R6: The victim is decoded from the current code with the checks taken in this order: way 0 when bits 5, 4 and 3 are all 1; else way 1 when bit 5 is 0 and bits 2 and 1 are 1; else way 2 when bits 4 and 2 are 0 and bit 0 is 1; else way 3 when bits 3, 1 and 0 are all 0.
- R7: A code that meets none of the four patterns sets the error flag and gives victim index 0. The flag is 0 for every other code.
- R8: A refill request without a code write reports the victim combinationally in the same cycle. On the next edge it applies that way's use update from R2 to R5.
- R9: A code write loads the written value on the next edge. It overrides a hit or a refill in the same cycle.
- R10: When a refill and a hit arrive in the same cycle without a write, the update is the one for the refill victim, and the hit has no effect.
- R11: With no write, no hit and no refill, the code holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| hitValid | input | 1 | A lookup hit a way this cycle |
| hitIdx | input | 2 | Way that was hit |
| refillReq | input | 1 | A new mapping is written into the victim way this cycle |
| codeWrEn | input | 1 | Software load of the recency code |
| codeWrData | input | 6 | Value to load |
| lruCode | output | 6 | Current recency code, bit 5 first |
| victimIdx | output | 2 | Way to replace on the next refill |
| lruErr | output | 1 | Current code matches no victim pattern |

## Verification
A wrong bit in the recency code shows up at the ports right away, because the code is an output. A wrong bit also shifts the victim index in the same cycle whenever it touches one of the three bits of the matching pattern. A corrupted update for a single way is therefore visible one edge after the hit, both in the code and usually in the victim. Chains of back-to-back refills expose a decoder or update fault within four cycles, since each refill moves the victim to a different way. A priority fault between write, refill and hit appears as a wrong code on the edge after the collision.

// File: rtl/itlb_lru_pkg.sv
package itlb_lru_pkg;
  localparam int NUM_WAYS = 4;
  localparam int IDX_W    = $clog2(NUM_WAYS);
  localparam int CODE_W   = NUM_WAYS * (NUM_WAYS - 1) / 2;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [IDX_W-1:0]  idx_t;

  // strobes from control to datapath
  typedef struct packed {
    logic doWrite;
    logic doUse;
    idx_t useIdx;
  } lru_strobe_t;

  // bits that a way's pattern examines (also the bits its use rewrites)
  function automatic code_t wayCare(input int w);
    case (w)
      0:       return 6'b111000;
      1:       return 6'b100110;
      2:       return 6'b010101;
      default: return 6'b001011;
    endcase
  endfunction

  // values those bits must hold for the way to be the oldest
  function automatic code_t wayOld(input int w);
    case (w)
      0:       return 6'b111000;
      1:       return 6'b000110;
      2:       return 6'b000001;
      default: return 6'b000000;
    endcase
  endfunction

  // a use drives the examined bits to the opposite of the "oldest" values
  function automatic code_t wayNew(input int w);
    return wayCare(w) & ~wayOld(w);
  endfunction
endpackage

// File: rtl/itlb_lru_victim.sv
module itlb_lru_victim
  import itlb_lru_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  code_t code,
  output idx_t  victim,
  output logic  noMatch
);
  logic [NUM_WAYS-1:0] matchVec;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_match
    assign matchVec[w] = ((code & wayCare(w)) == wayOld(w));
  end

  // fixed order: lowest way wins
  always_comb begin
    victim  = '0;
    noMatch = 1'b1;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (matchVec[w]) begin
        victim  = idx_t'(w);
        noMatch = 1'b0;
      end
    end
  end

  // R6: each pair of ways disagrees on one bit, so patterns never overlap
  match_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

  // R7
  err_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    noMatch |-> (victim == '0));
endmodule

// File: rtl/itlb_lru_ctrl.sv
module itlb_lru_ctrl
  import itlb_lru_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hitValid,
  input  idx_t        hitIdx,
  input  logic        refillReq,
  input  logic        codeWrEn,
  input  idx_t        victim,
  output lru_strobe_t strobe
);
  always_comb begin
    strobe.doWrite = codeWrEn;
    strobe.doUse   = !codeWrEn && (refillReq || hitValid);
    strobe.useIdx  = refillReq ? victim : hitIdx;
  end

  // R9
  wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.doWrite && strobe.doUse));
endmodule

// File: rtl/itlb_lru_dpath.sv
module itlb_lru_dpath
  import itlb_lru_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  lru_strobe_t strobe,
  input  code_t       wrData,
  output code_t       code
);
  code_t usedCode [NUM_WAYS];
  code_t codeNext;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_use
    assign usedCode[w] = (code & ~wayCare(w)) | wayNew(w);
  end

  always_comb begin
    codeNext = code;
    if (strobe.doWrite)     codeNext = wrData;
    else if (strobe.doUse)  codeNext = usedCode[strobe.useIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) code <= '0;
    else       code <= codeNext;
  end

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.doWrite && !strobe.doUse) |=> $stable(code));
endmodule

// File: rtl/itlb_lru_track.sv
module itlb_lru_track
  import itlb_lru_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hitValid,
  input  logic [1:0] hitIdx,
  input  logic       refillReq,
  input  logic       codeWrEn,
  input  logic [5:0] codeWrData,
  output logic [5:0] lruCode,
  output logic [1:0] victimIdx,
  output logic       lruErr
);
  lru_strobe_t strobe;

  itlb_lru_victim u_victim (
    .clk(clk), .rstN(rstN), .code(lruCode), .victim(victimIdx), .noMatch(lruErr)
  );

  itlb_lru_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hitValid(hitValid), .hitIdx(hitIdx),
    .refillReq(refillReq), .codeWrEn(codeWrEn), .victim(victimIdx), .strobe(strobe)
  );

  itlb_lru_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(codeWrData), .code(lruCode)
  );

  // R9
  wr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    codeWrEn |=> (lruCode == $past(codeWrData)));

  // R2
  use0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitValid && hitIdx == 2'd0 && !refillReq && !codeWrEn) |=>
      (lruCode[5:3] == 3'b000 && lruCode[2:0] == $past(lruCode[2:0])));

  // R5
  use3_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitValid && hitIdx == 2'd3 && !refillReq && !codeWrEn) |=>
      (lruCode[3] && lruCode[1] && lruCode[0]));

  // R8: a refilled way is never the next victim
  refill_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refillReq && !codeWrEn && !lruErr) |=> (victimIdx != $past(victimIdx)));
endmodule

// File: tb/itlb_lru_track_bench.sv
module itlb_lru_track_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hitValid = 1'b0;
  logic [1:0] hitIdx = '0;
  logic       refillReq = 1'b0;
  logic       codeWrEn = 1'b0;
  logic [5:0] codeWrData = '0;
  logic [5:0] lruCode;
  logic [1:0] victimIdx;
  logic       lruErr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [5:0] expCodeQ [$];
  logic [1:0] expVicQ  [$];
  logic       expErrQ  [$];
  string      tagQ     [$];

  logic [5:0] mCode = '0;

  always #5 clk = ~clk;

  itlb_lru_track u_itlb_lru_track (
    .clk(clk), .rstN(rstN), .hitValid(hitValid), .hitIdx(hitIdx),
    .refillReq(refillReq), .codeWrEn(codeWrEn), .codeWrData(codeWrData),
    .lruCode(lruCode), .victimIdx(victimIdx), .lruErr(lruErr)
  );

  // reference victim per R6 / R7
  function automatic logic [2:0] refVictim(input logic [5:0] c);
    if (c[5] && c[4] && c[3])            return {1'b0, 2'd0};
    else if (!c[5] && c[2] && c[1])      return {1'b0, 2'd1};
    else if (!c[4] && !c[2] && c[0])     return {1'b0, 2'd2};
    else if (!c[3] && !c[1] && !c[0])    return {1'b0, 2'd3};
    else                                 return {1'b1, 2'd0};
  endfunction

  // reference use update per R2..R5
  function automatic logic [5:0] refUse(input logic [5:0] c, input logic [1:0] w);
    logic [5:0] n = c;
    case (w)
      2'd0: begin n[5] = 0; n[4] = 0; n[3] = 0; end
      2'd1: begin n[5] = 1; n[2] = 0; n[1] = 0; end
      2'd2: begin n[4] = 1; n[2] = 1; n[0] = 0; end
      default: begin n[3] = 1; n[1] = 1; n[0] = 1; end
    endcase
    return n;
  endfunction

  task automatic check(input string tag, input logic [5:0] gc, input logic [1:0] gv,
                       input logic ge, input logic [5:0] ec, input logic [1:0] ev,
                       input logic ee);
    total++;
    if (gc !== ec || gv !== ev || ge !== ee) begin
      bad++;
      $display("FAIL %s: code=%b victim=%0d err=%b expected code=%b victim=%0d err=%b",
               tag, gc, gv, ge, ec, ev, ee);
    end
  endtask

  // driver: one cycle of stimulus, expected result pushed for the monitor
  task automatic step(input string tag, input logic wr, input logic [5:0] wd,
                      input logic hv, input logic [1:0] hi, input logic rf);
    logic [2:0] rv;
    @(negedge clk);
    codeWrEn = wr; codeWrData = wd; hitValid = hv; hitIdx = hi; refillReq = rf;
    #1;
    rv = refVictim(mCode);
    if (rf) check({tag, " same-cycle victim R8"}, lruCode, victimIdx, lruErr,
                  mCode, rv[1:0], rv[2]);
    if (wr)          mCode = wd;
    else if (rf)     mCode = refUse(mCode, rv[1:0]);
    else if (hv)     mCode = refUse(mCode, hi);
    rv = refVictim(mCode);
    expCodeQ.push_back(mCode);
    expVicQ.push_back(rv[1:0]);
    expErrQ.push_back(rv[2]);
    tagQ.push_back(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expCodeQ.size() > 0)
        check(tagQ.pop_front(), lruCode, victimIdx, lruErr,
              expCodeQ.pop_front(), expVicQ.pop_front(), expErrQ.pop_front());
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset", lruCode, victimIdx, lruErr, 6'b000000, 2'd3, 1'b0);
    @(negedge clk);
    rstN = 1'b1;

    step("R9 load all ones, R6 victim 0", 1, 6'b111111, 0, 0, 0);
    step("R3 hit way 1",                   0, 0, 1, 2'd1, 0);
    step("R4 hit way 2",                   0, 0, 1, 2'd2, 0);
    step("R5 hit way 3",                   0, 0, 1, 2'd3, 0);
    step("R2 hit way 0, R6 victim 1",      0, 0, 1, 2'd0, 0);
    step("R8 refill way 1",                0, 0, 0, 0, 1);
    step("R8 refill way 2",                0, 0, 0, 0, 1);
    step("R8 refill way 3",                0, 0, 0, 0, 1);
    step("R8 refill way 0",                0, 0, 0, 0, 1);
    step("R7 load code with no match",     1, 6'b100110, 0, 0, 0);
    step("R7 refill from error code",      0, 0, 0, 0, 1);
    step("R9 write beats hit",             1, 6'b000000, 1, 2'd1, 0);
    step("R10 refill beats hit",           0, 0, 1, 2'd0, 1);
    step("R9 write beats refill",          1, 6'b111000, 0, 0, 1);
    step("R11 idle hold",                  0, 0, 0, 0, 0);
    step("R11 idle hold again",            0, 0, 0, 0, 0);
    step("R2 hit way 0 on zero bits",      0, 0, 1, 2'd0, 0);
    step("R7 load code 000101",            1, 6'b000101, 0, 0, 0);

    for (int i = 0; i < 24; i++)
      step("R6 mixed hits", 0, 0, 1, 2'(i * 3 + i / 4), (i % 5) == 2);

    @(negedge clk);
    codeWrEn = 0; hitValid = 0; refillReq = 0;
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule